// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns a single read or write command into the stream of column addresses that an SDRAM burst visits. When a command arrives, it captures the start column and the burst settings from the mode inputs. From the next cycle it presents one column per clock, together with a valid strobe and a flag that marks the final beat. Each beat moves through the burst in either sequential (wrapping) or interleaved (XOR) order.

A burst can run for 1, 2, 4 or 8 beats, or for a whole 512-column page. A full-page burst keeps circling the page until a burst-stop or precharge command ends it. A new command can be issued on any cycle, and it abandons the burst in flight and restarts from the new column. A separate input makes every write a single beat while reads keep the programmed length. All outputs come from registers, so the controller that drives the command pins can use them directly on the following cycle.

Top module: `sdram_colgen`

## Requirements
- R1: While `rst` is high at a clock edge, `col_valid` and `col_last` are 0 after that edge. This holds even if a burst was running.
- R2: A read (`cmd_rd`) or write (`cmd_wr`) sampled on any edge makes `col_valid` 1 and `col_out` equal to `cmd_col` after that edge. A burst already in progress is abandoned.
- R3: `mode_bl` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. Codes 4 to 6 behave as length 1. A fixed-length burst gives exactly L valid beats, raises `col_last` only on beat L, and drops `col_valid` on the next cycle.
- R4: In sequential order (`mode_ilv`=0), beat i is at column base + ((start mod L) + i) mod L, where base is start with its low log2(L) bits cleared.
- R5: In interleaved order (`mode_ilv`=1), beat i is at column base + ((start mod L) XOR i).
- R6: A full-page burst steps through columns sequentially, modulo 512, and never raises `col_last`. It runs until it is terminated. With full page selected, `mode_ilv` is ignored.
- R7: A burst-stop (`cmd_bst`) or precharge (`cmd_pre`) ends the active burst, and `col_valid` is 0 after that edge. When the block is idle, these commands leave it idle.
- R8: With `mode_wr_single`=1, a write is one beat with `col_last`=1. Reads still use the length from `mode_bl`.
- R9: When a read or write arrives on the same edge as a burst-stop or precharge, the read or write wins. A command issued on the last beat of a burst starts the next burst with no idle cycle.
- R10: The mode inputs are sampled only when a command is accepted. Changing them during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_rd | input | 1 | Read command, starts a burst |
| cmd_wr | input | 1 | Write command, starts a burst |
| cmd_bst | input | 1 | Burst-stop command |
| cmd_pre | input | 1 | Precharge command, also ends a burst |
| cmd_col | input | COL_W (9) | Start column for read or write |
| mode_bl | input | 3 | Burst length code |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| mode_wr_single | input | 1 | 1 = writes are single-beat |
| col_out | output | COL_W (9) | Column of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | Current beat is the final one of a fixed burst |

## Verification
The case that needs the most care is when starting a burst and ending a burst fall on the same edge. This happens in two ways: a command lands on the final beat of a running burst, or a read arrives together with a burst-stop. The bench sets up both cases directly. It then checks that the new start column appears on the very next cycle with the strobe still high, and that the rest of the new burst follows the expected order. The checker also asserts, at the ports, that a start command always wins over a termination.

// File: rtl/sdram_colgen_pkg.sv
package sdram_colgen_pkg;
  localparam int MODE_BL_W = 3;

  typedef enum logic [MODE_BL_W-1:0] {
    BL_ONE  = 3'd0,
    BL_TWO  = 3'd1,
    BL_FOUR = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE = 3'd7
  } bl_code_e;
endpackage

// File: rtl/colgen_mode_dec.sv
module colgen_mode_dec
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [MODE_BL_W-1:0] bl_code,
  input  logic                 ilv_req,
  input  logic                 wr_single_req,
  input  logic                 is_write,
  output logic [COL_W-1:0]     wrap_mask,
  output logic                 full_page,
  output logic                 ilv_eff
);
  logic [COL_W-1:0] mask_raw;
  logic             page_raw;
  logic             force_one;

  always_comb begin
    mask_raw = '0;
    page_raw = 1'b0;
    case (bl_code)
      BL_ONE:   mask_raw = '0;
      BL_TWO:   mask_raw = COL_W'(1);
      BL_FOUR:  mask_raw = COL_W'(3);
      BL_EIGHT: mask_raw = COL_W'(7);
      BL_PAGE: begin
        mask_raw = '1;
        page_raw = 1'b1;
      end
      default:  mask_raw = '0;
    endcase
  end

  assign force_one = is_write & wr_single_req;
  assign wrap_mask = force_one ? '0 : mask_raw;
  assign full_page = page_raw & ~force_one;
  // interleaving over a full page is not a legal pairing; fall back to linear
  assign ilv_eff   = ilv_req & ~full_page;
endmodule

// File: rtl/colgen_addr.sv
module colgen_addr #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] beat_idx,
  input  logic [COL_W-1:0] wrap_mask,
  input  logic             ilv,
  output logic [COL_W-1:0] beat_col
);
  logic [COL_W-1:0] low_part;

  assign low_part = ilv ? (start_col ^ beat_idx) : (start_col + beat_idx);
  assign beat_col = (start_col & ~wrap_mask) | (low_part & wrap_mask);
endmodule

// File: rtl/sdram_colgen.sv
module sdram_colgen
  import sdram_colgen_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_rd,
  input  logic                 cmd_wr,
  input  logic                 cmd_bst,
  input  logic                 cmd_pre,
  input  logic [COL_W-1:0]     cmd_col,
  input  logic [MODE_BL_W-1:0] mode_bl,
  input  logic                 mode_ilv,
  input  logic                 mode_wr_single,
  output logic [COL_W-1:0]     col_out,
  output logic                 col_valid,
  output logic                 col_last
);
  logic             start_cmd;
  logic             stop_cmd;
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_ilv;

  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             ilv_q;
  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] idx_nxt;
  logic [COL_W-1:0] col_nxt;
  logic             last_nxt;

  assign start_cmd = cmd_rd | cmd_wr;
  assign stop_cmd  = cmd_bst | cmd_pre;

  colgen_mode_dec #(.COL_W(COL_W)) dec_i (
    .bl_code       (mode_bl),
    .ilv_req       (mode_ilv),
    .wr_single_req (mode_wr_single),
    .is_write      (cmd_wr & ~cmd_rd),
    .wrap_mask     (dec_mask),
    .full_page     (dec_full),
    .ilv_eff       (dec_ilv)
  );

  assign idx_nxt  = idx_q + COL_W'(1);
  assign last_nxt = ~full_q & (idx_nxt == mask_q);

  colgen_addr #(.COL_W(COL_W)) addr_i (
    .start_col (start_q),
    .beat_idx  (idx_nxt),
    .wrap_mask (mask_q),
    .ilv       (ilv_q),
    .beat_col  (col_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= '0;
      mask_q    <= '0;
      full_q    <= 1'b0;
      ilv_q     <= 1'b0;
      idx_q     <= '0;
      col_out   <= '0;
      col_valid <= 1'b0;
      col_last  <= 1'b0;
    end else if (start_cmd) begin
      start_q   <= cmd_col;
      mask_q    <= dec_mask;
      full_q    <= dec_full;
      ilv_q     <= dec_ilv;
      idx_q     <= '0;
      col_out   <= cmd_col;
      col_valid <= 1'b1;
      col_last  <= (dec_mask == '0);
    end else if (stop_cmd || col_last) begin
      col_valid <= 1'b0;
      col_last  <= 1'b0;
    end else if (col_valid) begin
      idx_q    <= idx_nxt;
      col_out  <= col_nxt;
      col_last <= last_nxt;
    end
  end
endmodule

// File: rtl/sdram_colgen_chk.sv
module sdram_colgen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_rd,
  input logic             cmd_wr,
  input logic             cmd_bst,
  input logic             cmd_pre,
  input logic [COL_W-1:0] cmd_col,
  input logic             mode_wr_single,
  input logic [COL_W-1:0] col_out,
  input logic             col_valid,
  input logic             col_last
);
  assert_last_has_valid_R3: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  assert_load_start_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd || cmd_wr) |=> (col_valid && col_out == $past(cmd_col)));

  assert_end_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    (col_valid && col_last && !cmd_rd && !cmd_wr) |=> !col_valid);

  assert_term_ends_R7: assert property (@(posedge clk) disable iff (rst)
    ((cmd_bst || cmd_pre) && !cmd_rd && !cmd_wr) |=> !col_valid);

  assert_single_write_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !cmd_rd && mode_wr_single) |=> (col_valid && col_last));

  assert_start_wins_R9: assert property (@(posedge clk) disable iff (rst)
    ((cmd_rd || cmd_wr) && (cmd_bst || cmd_pre)) |=> col_valid);
endmodule

bind sdram_colgen sdram_colgen_chk #(.COL_W(COL_W)) chk_i (
  .clk            (clk),
  .rst            (rst),
  .cmd_rd         (cmd_rd),
  .cmd_wr         (cmd_wr),
  .cmd_bst        (cmd_bst),
  .cmd_pre        (cmd_pre),
  .cmd_col        (cmd_col),
  .mode_wr_single (mode_wr_single),
  .col_out        (col_out),
  .col_valid      (col_valid),
  .col_last       (col_last)
);

// File: tb/sdram_colgen_tb.sv
module sdram_colgen_tb_top;
  localparam int COL_W = 9;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_bst = 1'b0, cmd_pre = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [2:0]       mode_bl = 3'd0;
  logic             mode_ilv = 1'b0;
  logic             mode_wr_single = 1'b0;
  logic [COL_W-1:0] col_out;
  logic             col_valid;
  logic             col_last;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  sdram_colgen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_bst(cmd_bst),
    .cmd_pre(cmd_pre), .cmd_col(cmd_col), .mode_bl(mode_bl), .mode_ilv(mode_ilv),
    .mode_wr_single(mode_wr_single), .col_out(col_out), .col_valid(col_valid),
    .col_last(col_last)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(input bit rd, input bit wr, input bit bst, input bit pre, input int col);
    cmd_rd = rd; cmd_wr = wr; cmd_bst = bst; cmd_pre = pre; cmd_col = COL_W'(col);
    step();
    cmd_rd = 0; cmd_wr = 0; cmd_bst = 0; cmd_pre = 0;
  endtask

  function automatic int exp_col(input int start, input int i, input int len, input bit ilv);
    int off = start % len;
    int base = start - off;
    if (ilv) return base + (off ^ i);
    return base + ((off + i) % len);
  endfunction

  // checks n beats, leaves time on the last checked beat
  task automatic expect_beats(input int start, input int len, input bit ilv, input int n,
                              input bit fixed, input string req);
    for (int i = 0; i < n; i++) begin
      chk({req, " valid"}, int'(col_valid), 1);
      chk({req, " col"}, int'(col_out), exp_col(start, i, len, ilv));
      chk({req, " last"}, int'(col_last), (fixed && i == len - 1) ? 1 : 0);
      if (i < n - 1) step();
    end
  endtask

  task automatic expect_idle(input string req);
    step();
    chk({req, " idle valid"}, int'(col_valid), 0);
    chk({req, " idle last"}, int'(col_last), 0);
  endtask

  task automatic t_reset();
    rst = 1; step(); step();
    chk("R1 reset valid", int'(col_valid), 0);
    chk("R1 reset last", int'(col_last), 0);
    rst = 0;
    mode_bl = 3; issue(1, 0, 0, 0, 20); step();
    rst = 1; step();
    chk("R1 reset mid-burst", int'(col_valid), 0);
    rst = 0; step();
    chk("R1 stays idle", int'(col_valid), 0);
  endtask

  task automatic t_lengths();
    mode_ilv = 0;
    for (int c = 0; c < 4; c++) begin
      mode_bl = 3'(c);
      issue(1, 0, 0, 0, 13);
      expect_beats(13, 1 << c, 0, 1 << c, 1, "R3 length");
      expect_idle("R3");
    end
    mode_bl = 3; issue(0, 1, 0, 0, 'h1FD);
    expect_beats('h1FD, 8, 0, 8, 1, "R4 seq wrap");
    expect_idle("R4");
    mode_bl = 5; issue(1, 0, 0, 0, 6);
    expect_beats(6, 1, 0, 1, 1, "R3 reserved code");
    expect_idle("R3 reserved");
  endtask

  task automatic t_interleave();
    mode_ilv = 1;
    mode_bl = 2; issue(1, 0, 0, 0, 5);
    expect_beats(5, 4, 1, 4, 1, "R5 ilv4");
    expect_idle("R5");
    mode_bl = 3; issue(1, 0, 0, 0, 'h0B);
    expect_beats('h0B, 8, 1, 8, 1, "R5 ilv8");
    expect_idle("R5");
    mode_ilv = 0;
  endtask

  task automatic t_full_page();
    mode_bl = 7; mode_ilv = 1;
    issue(1, 0, 0, 0, 'h1FE);
    expect_beats('h1FE, 512, 0, 520, 0, "R6 full page");
    cmd_bst = 1; step(); cmd_bst = 0;
    chk("R7 bst ends full page", int'(col_valid), 0);
    mode_ilv = 0;
  endtask

  task automatic t_terminate();
    mode_bl = 3;
    issue(1, 0, 0, 0, 'h20);
    expect_beats('h20, 8, 0, 3, 1, "R7 pre part");
    cmd_pre = 1; step(); cmd_pre = 0;
    chk("R7 pre ends burst", int'(col_valid), 0);
    expect_idle("R7 after pre");
    cmd_bst = 1; step(); cmd_bst = 0;
    chk("R7 idle bst valid", int'(col_valid), 0);
    chk("R7 idle bst last", int'(col_last), 0);
  endtask

  task automatic t_single_write();
    mode_bl = 3; mode_wr_single = 1;
    issue(0, 1, 0, 0, 'h40);
    expect_beats('h40, 1, 0, 1, 1, "R8 single write");
    expect_idle("R8 write");
    issue(1, 0, 0, 0, 'h40);
    expect_beats('h40, 8, 0, 8, 1, "R8 read full");
    expect_idle("R8 read");
    mode_wr_single = 0;
    issue(0, 1, 0, 0, 'h44);
    expect_beats('h44, 8, 0, 8, 1, "R8 write normal");
    expect_idle("R8 normal");
  endtask

  task automatic t_restart();
    mode_bl = 3;
    issue(1, 0, 0, 0, 'h10);
    expect_beats('h10, 8, 0, 3, 1, "R2 first");
    issue(1, 0, 0, 0, 'h33);
    expect_beats('h33, 8, 0, 8, 1, "R2 restart");
    expect_idle("R2");
    issue(1, 0, 0, 0, 'h60);
    expect_beats('h60, 8, 0, 2, 1, "R9 pre-collide");
    issue(1, 0, 1, 0, 'h50);
    expect_beats('h50, 8, 0, 8, 1, "R9 rd beats bst");
    expect_idle("R9");
    mode_bl = 1;
    issue(1, 0, 0, 0, 7);
    expect_beats(7, 2, 0, 2, 1, "R9 b2b first");
    issue(0, 1, 0, 0, 9);
    expect_beats(9, 2, 0, 2, 1, "R9 b2b second");
    expect_idle("R9 b2b");
  endtask

  task automatic t_mode_hold();
    mode_bl = 2; mode_ilv = 0;
    issue(1, 0, 0, 0, 'h81);
    mode_bl = 3; mode_ilv = 1;
    expect_beats('h81, 4, 0, 4, 1, "R10 mode held");
    expect_idle("R10");
    mode_ilv = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(); step();
    t_reset();
    t_lengths();
    t_interleave();
    t_full_page();
    t_terminate();
    t_single_write();
    t_restart();
    t_mode_hold();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule